// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Bit-Rate Clock Output

This block sends and receives asynchronous serial frames. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit and a high stop bit. A shared 16x timing tick drives both directions. The tick comes either from an internal programmable divider or from rising edges of an external clock on the serial clock pin. When the internal tick is in use, the block can also drive a clock at the bit rate on that pin. Each rising edge of this clock falls in the middle of a transmitted bit.

Software-side control is a set of plain level and strobe inputs. There are transmit and receive enables, a write strobe for the transmit data register, and a read strobe that empties the receive register. A separate strobe clears the error flags. Status comes out as levels: transmit-empty, receive-full, parity error, framing error and overrun. Turning the transmitter off abandons any frame in progress. Turning the receiver off leaves all received data and flags untouched.

Top module: `serial_xcvr`

## Requirements
- R1: After reset, tdre is 1, rx_full, per, fer and ore are 0, txd is 1 and sck_out is 1.
- R2: A transmitted frame is: start bit 0, then data bits 0 to 7, then the parity bit if par_en is 1, then stop bit 1. Each bit lasts 16 ticks. With the internal source, one tick occurs every baud_div+1 clock cycles.
- R3: A pulse on tdr_wr clears tdre at the next clock edge. While tx_en is 1 and the shifter is idle, the data moves into the shifter at the following edge, tdre returns to 1 and txd drops to the start bit.
- R4: clk_sel encoding: 2'b00 selects the internal tick with sck_oe 0. 2'b01 selects the internal tick with sck_oe 1. 2'b10 and 2'b11 take one tick per rising edge of sck_in, with sck_oe 0.
- R5: sck_out has the period of one bit. It is low for the first 8 ticks of each bit and high for the last 8, so it rises at the bit center. It is 1 while no frame is being sent.
- R6: The receiver starts on a falling edge of rxd and checks the line again on the 8th tick. A low pulse shorter than that is discarded. Later bits are sampled every 16 ticks. A good frame loads rdr and sets rx_full.
- R7: The parity bit makes the number of ones among data and parity even when par_odd is 0, and odd when par_odd is 1. A received mismatch sets per when par_en is 1.
- R8: A stop bit sampled as 0 sets fer. The frame is still stored in rdr and rx_full is set.
- R9: A frame that completes while rx_full is 1 sets ore. rdr, rx_full, per and fer keep their values.
- R10: rdr_rd clears rx_full. flag_clr clears per, fer and ore.
- R11: While tx_en is 0, tdre is 1, the shifter is idle and txd is 1 from the next edge. Re-enabling does not resume the abandoned frame.
- R12: While rx_en is 0, the receiver ignores rxd. rdr, rx_full, per, fer and ore keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_sel | input | 2 | Tick source and pin-drive select |
| baud_div | input | DIV_W | Internal divider: tick every baud_div+1 cycles |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tdr_wr | input | 1 | Transmit data register write strobe |
| tdr_data | input | 8 | Data written to the transmit register |
| rdr_rd | input | 1 | Receive register read strobe, clears rx_full |
| flag_clr | input | 1 | Clears per, fer and ore |
| sck_in | input | 1 | External 16x clock from the pin |
| sck_out | output | 1 | Bit-rate clock toward the pin |
| sck_oe | output | 1 | Pin drive enable for sck_out |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tdre | output | 1 | Transmit register empty |
| rx_full | output | 1 | Receive register holds unread data |
| per | output | 1 | Parity error flag |
| fer | output | 1 | Framing error flag |
| ore | output | 1 | Overrun flag |
| rdr | output | 8 | Receive data register |

## Verification
tdre changes one edge after a write and returns to 1 one edge after that, at the moment the start bit appears on txd. The bench checks each of these at the falling edge that follows the responsible rising edge. Transmitted bit k lasts from about 16·k·(baud_div+1) cycles to 16·(k+1)·(baud_div+1) cycles after the load. The bench samples txd at bit centers, which leaves half a bit of margin against tick phase. Received results are due at the stop-bit center plus two synchronizer cycles, and the bench reads flags only after the whole stop bit has been driven or after a bounded poll of rx_full.

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       clk_sel,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             par_en,
  input  logic             par_odd,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             tdr_wr,
  input  logic [7:0]       tdr_data,
  input  logic             rdr_rd,
  input  logic             flag_clr,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  input  logic             rxd,
  output logic             txd,
  output logic             tdre,
  output logic             rx_full,
  output logic             per,
  output logic             fer,
  output logic             ore,
  output logic [7:0]       rdr
);
  localparam int OS   = 16;
  localparam int SW   = $clog2(OS);
  localparam int MID  = OS/2 - 1;
  localparam int FRW  = 11;

  logic [1:0]       rxd_q, sck_q;
  logic             sck_d, rx_last;
  logic [DIV_W-1:0] div_cnt;
  logic             tick, int_tick, ext_tick;
  logic [3:0]       last_idx;

  assign rxd_s    = rxd_q[1];
  assign int_tick = (div_cnt == baud_div);
  assign ext_tick = sck_q[1] & ~sck_d;
  assign tick     = clk_sel[1] ? ext_tick : int_tick;
  assign last_idx = par_en ? 4'd10 : 4'd9;

  logic rxd_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxd_q <= '1; sck_q <= '0; sck_d <= 1'b0; rx_last <= 1'b1; div_cnt <= '0;
    end else begin
      rxd_q   <= {rxd_q[0], rxd};
      sck_q   <= {sck_q[0], sck_in};
      sck_d   <= sck_q[1];
      rx_last <= rxd_s;
      div_cnt <= int_tick ? '0 : div_cnt + 1'b1;
    end

  // transmitter
  logic [7:0]     tdr;
  logic [FRW-1:0] tx_sh;
  logic [SW-1:0]  tx_sub;
  logic [3:0]     tx_idx;
  logic           tx_busy, tx_load;

  assign tx_load = tx_en & ~tdre & ~tx_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tdr <= '0;
    else if (tdr_wr) tdr <= tdr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tdre <= 1'b1; tx_busy <= 1'b0; tx_sh <= '1; tx_sub <= '0; tx_idx <= '0;
    end else if (!tx_en) begin
      tdre <= 1'b1; tx_busy <= 1'b0; tx_sh <= '1; tx_sub <= '0; tx_idx <= '0;
    end else begin
      if (tx_load) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, par_en ? (^tdr ^ par_odd) : 1'b1, tdr, 1'b0};
        tx_sub  <= '0;
        tx_idx  <= '0;
        tdre    <= 1'b1;
      end else if (tx_busy && tick) begin
        tx_sub <= tx_sub + 1'b1;
        if (tx_sub == SW'(OS-1)) begin
          tx_sh  <= {1'b1, tx_sh[FRW-1:1]};
          tx_idx <= tx_idx + 1'b1;
          if (tx_idx == last_idx) tx_busy <= 1'b0;
        end
      end
      if (tdr_wr) tdre <= 1'b0;
    end

  assign txd     = tx_busy ? tx_sh[0] : 1'b1;
  assign sck_out = tx_busy ? tx_sub[SW-1] : 1'b1;
  assign sck_oe  = (clk_sel == 2'b01);

  // receiver
  logic [SW-1:0] rx_sub;
  logic [3:0]    rx_idx;
  logic [7:0]    rx_sh;
  logic          rx_par, rx_busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_sub <= '0; rx_idx <= '0; rx_sh <= '0; rx_par <= 1'b0;
      rdr <= '0; rx_full <= 1'b0; per <= 1'b0; fer <= 1'b0; ore <= 1'b0;
    end else begin
      if (rdr_rd) rx_full <= 1'b0;
      if (flag_clr) begin per <= 1'b0; fer <= 1'b0; ore <= 1'b0; end
      if (!rx_en) rx_busy <= 1'b0;
      else if (!rx_busy) begin
        if (rx_last && !rxd_s) begin
          rx_busy <= 1'b1; rx_sub <= '0; rx_idx <= '0;
        end
      end else if (tick) begin
        rx_sub <= rx_sub + 1'b1;
        if (rx_sub == SW'(MID)) begin
          rx_idx <= rx_idx + 1'b1;
          if (rx_idx == 4'd0) begin
            if (rxd_s) rx_busy <= 1'b0;
          end else if (rx_idx <= 4'd8) rx_sh <= {rxd_s, rx_sh[7:1]};
          else if (rx_idx == 4'd9 && par_en) rx_par <= rxd_s;
          if (rx_idx == last_idx) begin
            rx_busy <= 1'b0;
            if (rx_full && !rdr_rd) ore <= 1'b1;
            else begin
              rdr     <= rx_sh;
              rx_full <= 1'b1;
              fer     <= ~rxd_s;
              per     <= par_en & (^rx_sh ^ rx_par ^ par_odd);
            end
          end
        end
      end
    end

  p_txoff_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (tdre && txd && sck_out));
  p_rxoff_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !rdr_rd && !flag_clr) |=> ($stable(rdr) && $stable(rx_full) &&
      $stable(per) && $stable(fer) && $stable(ore)));
  p_ovr_needs_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ore) |-> ($past(rx_full) && $stable(rdr)));
  p_full_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(rx_en));
  p_edge_at_low_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && txd != $past(txd)) |-> !sck_out);
endmodule

// File: tb/sim_serial_xcvr.sv
module sim_serial_xcvr;
  logic clk = 0, rst_n = 0;
  logic [1:0] clk_sel = 2'b00;
  logic [15:0] baud_div = 16'd1;
  logic par_en = 0, par_odd = 0, tx_en = 0, rx_en = 0;
  logic tdr_wr = 0, rdr_rd = 0, flag_clr = 0;
  logic [7:0] tdr_data = 0;
  logic sck_in, loop_on = 0, rxd_tb = 1, ext_on = 0;
  logic sck_out, sck_oe, txd, tdre, rx_full, per, fer, ore;
  logic [7:0] rdr;
  logic rxd;
  int nchk = 0, nfail = 0;
  bit done = 0;

  assign rxd = loop_on ? txd : rxd_tb;
  always #5 clk = ~clk;

  serial_xcvr u0 (.clk, .rst_n, .clk_sel, .baud_div, .par_en, .par_odd, .tx_en,
    .rx_en, .tdr_wr, .tdr_data, .rdr_rd, .flag_clr, .sck_in, .sck_out, .sck_oe,
    .rxd, .txd, .tdre, .rx_full, .per, .fer, .ore, .rdr);

  // {data, par_en, par_odd}
  localparam logic [9:0] VEC [6] = '{
    {8'h55, 1'b0, 1'b0}, {8'hA3, 1'b1, 1'b0}, {8'h00, 1'b1, 1'b1},
    {8'hFF, 1'b1, 1'b0}, {8'h81, 1'b0, 1'b0}, {8'h3C, 1'b1, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_tdr(input logic [7:0] d);
    tdr_data = d; tdr_wr = 1; cyc(1); tdr_wr = 0;
  endtask

  task automatic pulse_rd_clr();
    rdr_rd = 1; flag_clr = 1; cyc(1); rdr_rd = 0; flag_clr = 0;
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic pe, input logic pv, input logic sb);
    rxd_tb = 0; cyc(32);
    for (int i = 0; i < 8; i++) begin rxd_tb = d[i]; cyc(32); end
    if (pe) begin rxd_tb = pv; cyc(32); end
    rxd_tb = sb; cyc(32);
    rxd_tb = 1; cyc(32);
  endtask

  task automatic wait_full(input int lim);
    for (int i = 0; i < lim && !rx_full; i++) cyc(1);
  endtask

  initial begin
    sck_in = 0;
    forever begin cyc(2); if (ext_on) sck_in = ~sck_in; end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog all requirements act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [10:0] fr;
    int rise;
    bit seen;
    cyc(3); rst_n = 1; cyc(1);
    chk("R1 tdre", tdre, 1); chk("R1 rx_full", rx_full, 0);
    chk("R1 flags", {per, fer, ore}, 0); chk("R1 txd", txd, 1);
    chk("R1 sck_out", sck_out, 1); chk("R4 sck_oe mode00", sck_oe, 0);

    // R3 / R2 / R5: direct transmit waveform in mode 01
    clk_sel = 2'b01; tx_en = 1; cyc(1);
    chk("R4 sck_oe mode01", sck_oe, 1);
    write_tdr(8'hB4);
    chk("R3 tdre cleared", tdre, 0);
    cyc(1);
    chk("R3 tdre set at transfer", tdre, 1);
    chk("R3 start bit", txd, 0);
    fr = {1'b1, 1'b1, 8'hB4, 1'b0};
    seen = 0; rise = 0;
    for (int c = 1; c <= 320; c++) begin
      cyc(1);
      if (c % 32 == 16) chk("R2 tx bit", txd, fr[c/32]);
      if (!seen && sck_out) begin seen = 1; rise = c; end
    end
    chk("R5 sck rise at mid start bit", (rise >= 14 && rise <= 18), 1);
    cyc(40);
    chk("R5 sck idle high", sck_out, 1);
    chk("R2 line idle", txd, 1);

    // vector table: loopback in mode 00
    clk_sel = 2'b00; loop_on = 1; rx_en = 1; cyc(4);
    for (int v = 0; v < 6; v++) begin
      par_en = VEC[v][1]; par_odd = VEC[v][0];
      write_tdr(VEC[v][9:2]);
      wait_full(1000);
      chk("R6 loopback data", rdr, VEC[v][9:2]);
      chk("R7 loopback parity ok", per, 0);
      pulse_rd_clr();
      cyc(40);
    end
    loop_on = 0; par_en = 0; par_odd = 0; cyc(4);

    // R8 framing error
    rx_frame(8'h5A, 0, 0, 0);
    chk("R8 fer", fer, 1); chk("R8 stored", rdr, 8'h5A); chk("R8 full", rx_full, 1);
    pulse_rd_clr();
    chk("R10 rx_full cleared", rx_full, 0); chk("R10 fer cleared", fer, 0);

    // R7 parity error: 8'h07 even needs parity 1, send 0
    par_en = 1; cyc(1);
    rx_frame(8'h07, 1, 0, 1);
    chk("R7 per", per, 1); chk("R7 data", rdr, 8'h07);

    // R12 receiver disabled keeps everything
    rx_en = 0; cyc(1);
    rx_frame(8'h99, 1, 0, 1);
    chk("R12 rdr kept", rdr, 8'h07); chk("R12 full kept", rx_full, 1);
    chk("R12 per kept", per, 1); chk("R12 no ore", ore, 0);
    pulse_rd_clr(); rx_en = 1; par_en = 0; cyc(4);

    // R9 overrun
    rx_frame(8'h11, 0, 0, 1);
    rx_frame(8'h22, 0, 0, 1);
    chk("R9 ore", ore, 1); chk("R9 rdr kept", rdr, 8'h11); chk("R9 full kept", rx_full, 1);
    chk("R9 fer unchanged", fer, 0);
    pulse_rd_clr();
    chk("R10 ore cleared", ore, 0); chk("R10 full cleared", rx_full, 0);

    // R6 short glitch discarded
    rxd_tb = 0; cyc(6); rxd_tb = 1; cyc(400);
    chk("R6 glitch ignored", rx_full, 0);
    rx_frame(8'hC6, 0, 0, 1);
    chk("R6 valid after glitch", rdr, 8'hC6);
    pulse_rd_clr();

    // R11 transmitter disabled mid-frame
    rx_en = 0; write_tdr(8'h00); cyc(40);
    tx_en = 0; cyc(1);
    chk("R11 tdre forced", tdre, 1); chk("R11 txd idle", txd, 1);
    tx_en = 1; cyc(200);
    chk("R11 no resume", txd, 1); chk("R11 tdre stays", tdre, 1);

    // R4 external 16x clock
    clk_sel = 2'b10; ext_on = 1; rx_en = 1; loop_on = 1; cyc(8);
    chk("R4 sck_oe ext", sck_oe, 0);
    write_tdr(8'h6D); cyc(1);
    cyc(48);
    chk("R4 ext rate start bit held", txd, 0);
    wait_full(2000);
    chk("R4 ext loopback", rdr, 8'h6D);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule